// File: doc/BRIEF.md
# Host Interrupt Status and Enable Unit

This unit keeps the pending-event flags and the enable mask for a host controller, and from them it drives one level-sensitive interrupt line. Event sources elsewhere in the controller raise single-cycle pulses on a 32-bit event input. Each pulse latches the matching pending flag. Software reaches the unit through a simple word-wide register port. On the pending-flag offset, software acknowledges events by writing ones. The enable mask has two offsets: one that turns bits on and one that turns them off. Because of this split, software never needs a read-modify-write of the mask.

Bit 31 of the enable mask is a global gate. While it is clear, the interrupt line stays low whatever is pending. The unit implements eight event sources at fixed bit positions, and every other bit position reads as zero. The unit has no sequencing of its own. All of its behaviour is register updates at the clock edge and combinational read-out.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After a synchronous active-low reset, the pending register reads 0, the enable register reads 0x80000000, and `irq` is low.
- R2: The implemented source bits are 0 overrun, 1 done-list written, 2 frame start, 3 resume seen, 4 fatal error, 5 frame counter wrap, 6 hub change and 30 ownership change. A 1 on `hw_event` at one of these bits sets that pending bit at the next clock edge. The bit then stays set until software clears it.
- R3: A write to offset 0x0C clears each pending bit written as 1 and leaves the bits written as 0 unchanged.
- R4: If a hardware event and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R5: A write to offset 0x10 ORs the written bits into the enable register. Bits written as 0 are left unchanged.
- R6: A write to offset 0x14 clears each enable bit written as 1, including the global gate at bit 31.
- R7: A read at offset 0x10 and a read at offset 0x14 both return the enable register. A read at offset 0x0C returns the pending register. The read data is combinational from `reg_addr`.
- R8: `irq` is high exactly when enable bit 31 is set and some pending bit is also enabled. It follows any register change in the cycle that change becomes visible.
- R9: Pending bits outside the implemented set, and enable bits outside that set plus bit 31, always read 0 and cannot be set.
- R10: A write to any other offset changes no register, and a read at any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hw_event | input | 32 | Event pulses, one bit per source |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq | output | 1 | Level interrupt request |

## Verification
Two things can hit the same pending bit in one clock: a hardware event and a software acknowledge. The bench provokes this directly by pulsing a source while writing a one to that bit at 0x0C, and requires the bit to stay set. Random traffic also overlaps events with status writes on many bits at once. A bench model applies the clear first and then ORs in the events, and the bench checks every register read-back and the `irq` level against that model after each cycle.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
    localparam int          DW        = 32;
    localparam int          MIE_POS   = 31;
    localparam logic [31:0] SRC_MASK  = 32'h4000_007F;
    localparam logic [31:0] GATE_BIT  = 32'h8000_0000;
    localparam logic [31:0] ENA_MASK  = SRC_MASK | GATE_BIT;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_STATUS,
        ACC_EN_SET,
        ACC_EN_CLR
    } acc_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_unit_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] OFS_STATUS = 8'h0C,
    parameter logic [ADDR_W-1:0] OFS_EN_SET = 8'h10,
    parameter logic [ADDR_W-1:0] OFS_EN_CLR = 8'h14
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_e              sel
);
    always_comb begin
        if (addr == OFS_STATUS)      sel = ACC_STATUS;
        else if (addr == OFS_EN_SET) sel = ACC_EN_SET;
        else if (addr == OFS_EN_CLR) sel = ACC_EN_CLR;
        else                         sel = ACC_NONE;
    end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int           W    = 32,
    parameter logic [W-1:0] IMPL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hw_set,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] status
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (hw_set[i])
                bit_q <= IMPL[i];
            else if (clr_en && clr_bits[i])
                bit_q <= 1'b0;
        end
        assign status[i] = bit_q & IMPL[i];
    end
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
    parameter int           W       = 32,
    parameter logic [W-1:0] IMPL    = '0,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] bits,
    output logic [W-1:0] enable
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= RST_VAL[i];
            else if (set_en && bits[i])
                bit_q <= IMPL[i];
            else if (clr_en && bits[i])
                bit_q <= 1'b0;
        end
        assign enable[i] = bit_q & IMPL[i];
    end
endmodule

// File: rtl/irq_level_drv.sv
module irq_level_drv #(
    parameter int W       = 32,
    parameter int GATE_AT = 31
) (
    input  logic [W-1:0] status,
    input  logic [W-1:0] enable,
    output logic         irq
);
    localparam logic [W-1:0] SRC_ONLY = ~(W'(1) << GATE_AT);
    logic [W-1:0] hits;
    always_comb begin
        hits = status & enable & SRC_ONLY;
        irq  = enable[GATE_AT] & (|hits);
    end
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
    import irq_unit_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] OFS_STATUS = 8'h0C,
    parameter logic [ADDR_W-1:0] OFS_EN_SET = 8'h10,
    parameter logic [ADDR_W-1:0] OFS_EN_CLR = 8'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     hw_event,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq
);
    acc_e          sel;
    logic [DW-1:0] status_q;
    logic [DW-1:0] enable_q;
    logic [DW-1:0] evt_masked;

    assign evt_masked = hw_event & SRC_MASK;

    irq_reg_decode #(
        .ADDR_W(ADDR_W), .OFS_STATUS(OFS_STATUS),
        .OFS_EN_SET(OFS_EN_SET), .OFS_EN_CLR(OFS_EN_CLR)
    ) u_dec (
        .addr(reg_addr),
        .sel (sel)
    );

    irq_status_bank #(.W(DW), .IMPL(SRC_MASK)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_set  (evt_masked),
        .clr_en  (reg_wr && sel == ACC_STATUS),
        .clr_bits(reg_wdata),
        .status  (status_q)
    );

    irq_enable_bank #(.W(DW), .IMPL(ENA_MASK), .RST_VAL(GATE_BIT)) u_ena (
        .clk   (clk),
        .rst_n (rst_n),
        .set_en(reg_wr && sel == ACC_EN_SET),
        .clr_en(reg_wr && sel == ACC_EN_CLR),
        .bits  (reg_wdata),
        .enable(enable_q)
    );

    irq_level_drv #(.W(DW), .GATE_AT(MIE_POS)) u_lvl (
        .status(status_q),
        .enable(enable_q),
        .irq   (irq)
    );

    always_comb begin
        unique case (sel)
            ACC_STATUS: reg_rdata = status_q;
            ACC_EN_SET: reg_rdata = enable_q;
            ACC_EN_CLR: reg_rdata = enable_q;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker
    import irq_unit_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] OFS_STATUS = 8'h0C,
    parameter logic [ADDR_W-1:0] OFS_EN_SET = 8'h10,
    parameter logic [ADDR_W-1:0] OFS_EN_CLR = 8'h14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DW-1:0]     hw_event,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic              irq,
    input logic [DW-1:0]     status_q,
    input logic [DW-1:0]     enable_q
);
    logic wr_stat, wr_set, wr_clr;
    assign wr_stat = reg_wr && reg_addr == OFS_STATUS;
    assign wr_set  = reg_wr && reg_addr == OFS_EN_SET;
    assign wr_clr  = reg_wr && reg_addr == OFS_EN_CLR;

    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_event & SRC_MASK) != 0) |=>
        ((status_q & $past(hw_event & SRC_MASK)) == $past(hw_event & SRC_MASK)));

    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((status_q & $past(reg_wdata & ~hw_event)) == 0));

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && ((reg_wdata & hw_event & SRC_MASK) != 0)) |=>
        ((status_q & $past(reg_wdata & hw_event & SRC_MASK)) != 0));

    p_en_or_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((enable_q & $past(reg_wdata & ENA_MASK)) == $past(reg_wdata & ENA_MASK)));

    p_en_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((enable_q & $past(reg_wdata)) == 0));

    p_gate_needed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> enable_q[MIE_POS]);

    p_no_hit_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & enable_q) == 0) |-> !irq);

    p_unimpl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~SRC_MASK) == 0) && ((enable_q & ~ENA_MASK) == 0));

    p_en_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(enable_q));
endmodule

bind irq_ctrl_unit irq_ctrl_checker #(
    .ADDR_W(ADDR_W), .OFS_STATUS(OFS_STATUS),
    .OFS_EN_SET(OFS_EN_SET), .OFS_EN_CLR(OFS_EN_CLR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_event (hw_event),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .irq      (irq),
    .status_q (status_q),
    .enable_q (enable_q)
);

// File: tb/tb_irq_ctrl_unit.sv
module tb_irq_ctrl_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_ST  = 8'h0C;
    localparam logic [7:0] A_SET = 8'h10;
    localparam logic [7:0] A_CLR = 8'h14;
    localparam logic [7:0] A_BAD = 8'h18;
    localparam logic [31:0] M_SRC = 32'h4000_007F;
    localparam logic [31:0] M_ENA = 32'hC000_007F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] hw_event = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [31:0] m_st, m_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ctrl_unit dut (
        .clk(clk), .rst_n(rst_n), .hw_event(hw_event), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] nxt_st(logic [31:0] st, logic wr, logic [7:0] a,
                                           logic [31:0] d, logic [31:0] e);
        logic [31:0] c;
        c = (wr && a == A_ST) ? d : 32'h0;
        return ((st & ~c) | (e & M_SRC)) & M_SRC;
    endfunction

    function automatic logic [31:0] nxt_en(logic [31:0] en, logic wr, logic [7:0] a,
                                           logic [31:0] d);
        if (wr && a == A_SET) return (en | d) & M_ENA;
        if (wr && a == A_CLR) return en & ~d;
        return en;
    endfunction

    function automatic logic exp_irq(logic [31:0] st, logic [31:0] en);
        return en[31] && ((st & en & 32'h7FFF_FFFF) != 0);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic step(logic wr, logic [7:0] a, logic [31:0] d, logic [31:0] e);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; hw_event = e;
        @(posedge clk);
        m_st = nxt_st(m_st, wr, a, d, e);
        m_en = nxt_en(m_en, wr, a, d);
    endtask

    task automatic check_all(string req);
        @(negedge clk);
        reg_wr = 1'b0; hw_event = '0;
        reg_addr = A_ST;  #1 check({req, " status read (R7)"}, reg_rdata, m_st);
        reg_addr = A_SET; #1 check({req, " enable via set offset (R7)"}, reg_rdata, m_en);
        reg_addr = A_CLR; #1 check({req, " enable via clear offset (R7)"}, reg_rdata, m_en);
        check({req, " irq level (R8)"}, {31'h0, irq}, {31'h0, exp_irq(m_st, m_en)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_st = '0; m_en = 32'h8000_0000;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        check_all("R1 reset");
        check("R1 reset enable value", m_en, 32'h8000_0000);
        check("R1 irq low after reset", {31'h0, irq}, 32'h0);

        // R2: hub change event sets bit 6, irq stays low while not enabled
        step(1'b0, A_ST, 0, 32'h0000_0040);
        check_all("R2 event bit6");
        step(1'b0, A_ST, 0, 32'h0);
        check_all("R2 bit held");

        // R5: enable bit 6 -> irq high
        step(1'b1, A_SET, 32'h0000_0040, 0);
        check_all("R5 set enable");
        check("R8 irq with gate and source", {31'h0, irq}, 32'h1);

        // R6: clearing gate silences irq
        step(1'b1, A_CLR, 32'h8000_0000, 0);
        check_all("R6 clear gate");
        check("R8 gate off", {31'h0, irq}, 32'h0);
        step(1'b1, A_SET, 32'h8000_0000, 0);
        check_all("R5 gate back");

        // R3: write-one-to-clear with mixed bits
        step(1'b0, A_ST, 0, 32'h4000_0005);
        step(1'b1, A_ST, 32'h0000_0041, 0);
        check_all("R3 w1c");
        check("R3 remaining bits", m_st, 32'h4000_0004);

        // R4: set and clear of bit 2 in the same cycle
        step(1'b1, A_ST, 32'h0000_0004, 32'h0000_0004);
        check_all("R4 collision");
        reg_addr = A_ST; #1 check("R4 bit2 stays set", reg_rdata & 32'h4, 32'h4);

        // R9: unimplemented bits
        step(1'b1, A_SET, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check_all("R9 all ones");
        reg_addr = A_ST;  #1 check("R9 status unimpl zero", reg_rdata & ~M_SRC, 0);
        reg_addr = A_SET; #1 check("R9 enable unimpl zero", reg_rdata & ~M_ENA, 0);

        // R10: other offset
        step(1'b1, A_BAD, 32'hFFFF_FFFF, 0);
        check_all("R10 bad write");
        reg_addr = A_BAD; #1 check("R10 bad read zero", reg_rdata, 0);

        // random traffic
        for (int it = 0; it < 300; it++) begin
            logic [7:0]  a;
            logic [31:0] d, e;
            logic        w;
            case ($urandom % 5)
                0: a = A_ST;
                1: a = A_SET;
                2: a = A_CLR;
                3: a = A_BAD;
                default: a = A_ST;
            endcase
            w = ($urandom % 4) != 0;
            d = $urandom;
            e = (($urandom % 3) == 0) ? $urandom : 32'h0;
            step(w, a, d, e);
            check_all("R2/R3/R4/R5/R6 random");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule